// File: doc/BRIEF.md
# Power Island Reset and Clock Sequencer

This block brings three peripheral sub-domains of one shared power island up and down in a safe order. Each sub-domain has an active-low soft reset line and a clock enable line, and each has its own request/acknowledge handshake with an external power controller. A fourth handshake powers the shared bus portion of the island. The bus portion comes up with the first sub-domain and goes down only after the last one has gone. While the bus comes up, every sub-domain clock is ungated for a short time so that the bus bridge can finish its handshake. Four strap registers are then restored to all ones.

Each sub-domain has a one-cycle pulse input that asks for power-on and another that asks for power-off. The sequencer runs one transition at a time. Requests that arrive while a transition is running are remembered and served later in a fixed priority order. Software can reach the reset, clock and strap registers through a small register port. These registers exist only while the island has power. They come back cleared after every collapse.

Top module: `pwr_island_seq`

## Requirements
- R1: A sub-domain power request (`sub_pwr_req`) is raised only while the bus domain is both requested and acknowledged. The first power-on request raises `bus_pwr_req` before any sub-domain request.
- R2: Once the bus acknowledge arrives, all three reset bits are driven low and all three clock bits are driven high for the settle window. After that window the clock bits return to zero.
- R3: When a sub-domain is powered on, its reset bit is already low and its clock bit already high at the moment its `sub_pwr_req` rises.
- R4: A sub-domain's reset is released no earlier than WAIT_CYC cycles after its power acknowledge is seen, with WAIT_CYC = CLK_FREQ_HZ x SETTLE_NS / 1e9 (250 at the default values). It is released within a few cycles after that.
- R5: Bit 0 belongs to sub-domain G2, bit 1 to G1 and bit 2 to H1, on every per-domain port. The register at offset 0x00 is the active-low reset vector and drives `sub_rst_n`. The register at 0x04 is the clock enable vector and drives `sub_clk_en`. All outputs are zero after reset.
- R6: When a sub-domain is powered off, its reset bit and its clock bit are both low before its `sub_pwr_req` falls.
- R7: The bus domain stays powered while any sub-domain is still on.
- R8: Before `bus_pwr_req` falls, all reset bits are low and all clock bits are high. Once the island has lost power, every register reads back as zero.
- R9: Reads return zero while the bus domain is not both requested and acknowledged. Writes made during that time have no effect.
- R10: While the island is up, software writes to offsets 0x00, 0x04 and 0x08 to 0x14 take effect, so a clock can be gated with its domain still on. Reads at offset 0x18 and above, or at an unaligned address, return zero.
- R11: Pending requests are served one at a time, in the priority order G1, then G2, then H1.
- R12: A power-on request for a domain that is already on has no effect. So does a power-off request for a domain that is already off.
- R13: The four strap registers (offsets 0x08, 0x0C, 0x10, 0x14) are set to all ones on every bus power-up, whatever software wrote to them before the island collapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pon_req | input | 3 | One-cycle power-on request per sub-domain |
| poff_req | input | 3 | One-cycle power-off request per sub-domain |
| bus_pwr_req | output | 1 | Bus domain power request to the power controller |
| bus_pwr_ack | input | 1 | Bus domain power acknowledge |
| sub_pwr_req | output | 3 | Sub-domain power requests |
| sub_pwr_ack | input | 3 | Sub-domain power acknowledges |
| sub_rst_n | output | 3 | Active-low soft resets to the peripherals |
| sub_clk_en | output | 3 | Clock enables to the peripherals |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
Some ordering rules are checked by assertions on every cycle:
- the bus is up whenever a sub-domain is requested;
- reset and clock are in their safe state on every edge of a sub-domain request;
- the bridge pattern is present when the bus request falls;
- reads are dead while the island is off;
- storage is wiped after a collapse;
- only one sub-domain request changes at a time;
- reset is never released before the settle window has passed, which a cycle counter measures.

Other behaviour appears only in the bench scenarios:
- the order in which a group of queued requests is served;
- that redundant requests are ignored;
- that software can gate a clock while the island is up;
- the address decode, including out-of-range and unaligned reads;
- that the straps are restored after software overwrote them and the island then collapsed.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int NDOM   = 3;
  localparam int NSTRAP = 4;
  localparam int NREG   = 2 + NSTRAP;

  localparam logic [NDOM-1:0] M_G2 = 3'b001;
  localparam logic [NDOM-1:0] M_G1 = 3'b010;
  localparam logic [NDOM-1:0] M_H1 = 3'b100;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BUS_REQ,
    S_BUS_BRIDGE,
    S_BUS_SETTLE,
    S_BUS_STRAP,
    S_SUB_PREP,
    S_SUB_REQ,
    S_SUB_SETTLE,
    S_SUB_REL,
    S_OFF_PREP,
    S_OFF_DROP,
    S_BUS_DN_PREP,
    S_BUS_DN_DROP
  } seq_state_e;

  typedef struct packed {
    logic            wr_rst;
    logic [NDOM-1:0] rst_val;
    logic            wr_clk;
    logic [NDOM-1:0] clk_val;
    logic            set_straps;
  } seq_wr_t;
endpackage

// File: rtl/pis_settle_timer.sv
module pis_settle_timer #(
  parameter int WAIT_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = CW'(WAIT_CYC - 1);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign done = run_q && (cnt_q == '0) && !start;

  p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/pis_regfile.sv
module pis_regfile
  import pis_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DW-1:0]     sw_wdata,
  input  seq_wr_t           seq,
  output logic [DW-1:0]     rdata,
  output logic [NDOM-1:0]   rst_bits,
  output logic [NDOM-1:0]   clk_bits
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] OFS_END = ADDR_W'(NREG * 4);

  logic [NDOM-1:0]             rst_q, rst_d;
  logic [NDOM-1:0]             clk_q, clk_d;
  logic [NSTRAP-1:0][DW-1:0]   strap_q, strap_d;
  logic [IDX_W-1:0]            widx;
  logic                        addr_ok;

  assign widx    = sw_addr[ADDR_W-1:2];
  assign addr_ok = (sw_addr[1:0] == 2'b00) && (sw_addr < OFS_END);

  always_comb begin
    rst_d   = rst_q;
    clk_d   = clk_q;
    strap_d = strap_q;
    if (!live) begin
      rst_d   = '0;
      clk_d   = '0;
      strap_d = '0;
    end else begin
      if (sw_wr && addr_ok) begin
        if (widx == IDX_W'(0)) rst_d = sw_wdata[NDOM-1:0];
        if (widx == IDX_W'(1)) clk_d = sw_wdata[NDOM-1:0];
        for (int k = 0; k < NSTRAP; k++)
          if (widx == IDX_W'(k + 2)) strap_d[k] = sw_wdata;
      end
      if (seq.wr_rst)     rst_d   = seq.rst_val;
      if (seq.wr_clk)     clk_d   = seq.clk_val;
      if (seq.set_straps) strap_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= '0;
      clk_q   <= '0;
      strap_q <= '0;
    end else begin
      rst_q   <= rst_d;
      clk_q   <= clk_d;
      strap_q <= strap_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (live && addr_ok) begin
      if (widx == IDX_W'(0)) rdata = DW'(rst_q);
      if (widx == IDX_W'(1)) rdata = DW'(clk_q);
      for (int k = 0; k < NSTRAP; k++)
        if (widx == IDX_W'(k + 2)) rdata = strap_q[k];
    end
  end

  assign rst_bits = rst_q;
  assign clk_bits = clk_q;

  p_island_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (rst_q == '0 && clk_q == '0 && strap_q == '0));
endmodule

// File: rtl/pis_seq_ctrl.sv
module pis_seq_ctrl
  import pis_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDOM-1:0] pon_req,
  input  logic [NDOM-1:0] poff_req,
  input  logic            bus_pwr_ack,
  input  logic [NDOM-1:0] sub_pwr_ack,
  input  logic [NDOM-1:0] rst_bits,
  input  logic [NDOM-1:0] clk_bits,
  input  logic            tmr_done,
  output logic            tmr_start,
  output logic            bus_pwr_req,
  output logic [NDOM-1:0] sub_pwr_req,
  output seq_wr_t         seq,
  output logic            live
);
  seq_state_e      st_q, st_d;
  logic [NDOM-1:0] cur_q, cur_d;
  logic [NDOM-1:0] on_q, on_d;
  logic [NDOM-1:0] pend_on_q, pend_on_d;
  logic [NDOM-1:0] pend_off_q, pend_off_d;
  logic [NDOM-1:0] sub_req_q, sub_req_d;
  logic            bus_req_q, bus_req_d;
  logic [NDOM-1:0] want, pick;

  // fixed service priority: G1, then G2, then H1
  always_comb begin
    pick = '0;
    if      ((want & M_G1) != '0) pick = M_G1;
    else if ((want & M_G2) != '0) pick = M_G2;
    else if ((want & M_H1) != '0) pick = M_H1;
  end

  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    on_d       = on_q;
    sub_req_d  = sub_req_q;
    bus_req_d  = bus_req_q;
    tmr_start  = 1'b0;
    seq        = '0;
    pend_on_d  = (pend_on_q & ~poff_req) | pon_req;
    pend_off_d = (pend_off_q | poff_req) & ~pon_req;
    want       = '0;

    case (st_q)
      S_IDLE: begin
        pend_on_d  = pend_on_d & ~on_q;
        pend_off_d = pend_off_d & on_q;
        want       = pend_on_d | pend_off_d;
        if (want != '0) begin
          cur_d      = pick;
          pend_on_d  = pend_on_d & ~pick;
          pend_off_d = pend_off_d & ~pick;
          if ((on_q & pick) != '0) st_d = S_OFF_PREP;
          else if (bus_req_q)      st_d = S_SUB_PREP;
          else                     st_d = S_BUS_REQ;
        end
      end
      S_BUS_REQ: begin
        bus_req_d = 1'b1;
        if (bus_req_q && bus_pwr_ack) st_d = S_BUS_BRIDGE;
      end
      S_BUS_BRIDGE: begin
        seq.wr_rst  = 1'b1;
        seq.rst_val = '0;
        seq.wr_clk  = 1'b1;
        seq.clk_val = '1;
        tmr_start   = 1'b1;
        st_d        = S_BUS_SETTLE;
      end
      S_BUS_SETTLE: begin
        if (tmr_done) st_d = S_BUS_STRAP;
      end
      S_BUS_STRAP: begin
        seq.set_straps = 1'b1;
        seq.wr_clk     = 1'b1;
        seq.clk_val    = '0;
        st_d           = S_SUB_PREP;
      end
      S_SUB_PREP: begin
        seq.wr_rst  = 1'b1;
        seq.rst_val = rst_bits & ~cur_q;
        seq.wr_clk  = 1'b1;
        seq.clk_val = clk_bits | cur_q;
        st_d        = S_SUB_REQ;
      end
      S_SUB_REQ: begin
        sub_req_d = sub_req_q | cur_q;
        if ((sub_req_q & cur_q) != '0 && (sub_pwr_ack & cur_q) != '0) begin
          tmr_start = 1'b1;
          st_d      = S_SUB_SETTLE;
        end
      end
      S_SUB_SETTLE: begin
        if (tmr_done) st_d = S_SUB_REL;
      end
      S_SUB_REL: begin
        seq.wr_rst  = 1'b1;
        seq.rst_val = rst_bits | cur_q;
        on_d        = on_q | cur_q;
        st_d        = S_IDLE;
      end
      S_OFF_PREP: begin
        seq.wr_rst  = 1'b1;
        seq.rst_val = rst_bits & ~cur_q;
        seq.wr_clk  = 1'b1;
        seq.clk_val = clk_bits & ~cur_q;
        st_d        = S_OFF_DROP;
      end
      S_OFF_DROP: begin
        sub_req_d = sub_req_q & ~cur_q;
        if ((sub_req_q & cur_q) == '0 && (sub_pwr_ack & cur_q) == '0) begin
          on_d = on_q & ~cur_q;
          st_d = ((on_q & ~cur_q) == '0) ? S_BUS_DN_PREP : S_IDLE;
        end
      end
      S_BUS_DN_PREP: begin
        seq.wr_rst  = 1'b1;
        seq.rst_val = '0;
        seq.wr_clk  = 1'b1;
        seq.clk_val = '1;
        st_d        = S_BUS_DN_DROP;
      end
      S_BUS_DN_DROP: begin
        bus_req_d = 1'b0;
        if (!bus_req_q && !bus_pwr_ack) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cur_q      <= '0;
      on_q       <= '0;
      pend_on_q  <= '0;
      pend_off_q <= '0;
      sub_req_q  <= '0;
      bus_req_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      cur_q      <= cur_d;
      on_q       <= on_d;
      pend_on_q  <= pend_on_d;
      pend_off_q <= pend_off_d;
      sub_req_q  <= sub_req_d;
      bus_req_q  <= bus_req_d;
    end
  end

  assign bus_pwr_req = bus_req_q;
  assign sub_pwr_req = sub_req_q;
  assign live        = bus_req_q & bus_pwr_ack;

  p_bus_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_req_q != '0) |-> (bus_req_q && bus_pwr_ack));

  p_one_at_a_time_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sub_req_q ^ $past(sub_req_q)) <= 1);
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
  import pis_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int SETTLE_NS   = 5000,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pon_req,
  input  logic [2:0]        poff_req,
  output logic              bus_pwr_req,
  input  logic              bus_pwr_ack,
  output logic [2:0]        sub_pwr_req,
  input  logic [2:0]        sub_pwr_ack,
  output logic [2:0]        sub_rst_n,
  output logic [2:0]        sub_clk_en,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int WAIT_RAW = (CLK_FREQ_HZ / 1000) * SETTLE_NS / 1_000_000;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int HC_W     = $clog2(WAIT_CYC + 1);

  seq_wr_t         seq;
  logic            live, tmr_start, tmr_done;
  logic [NDOM-1:0] rst_bits, clk_bits;

  pis_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pon_req     (pon_req),
    .poff_req    (poff_req),
    .bus_pwr_ack (bus_pwr_ack),
    .sub_pwr_ack (sub_pwr_ack),
    .rst_bits    (rst_bits),
    .clk_bits    (clk_bits),
    .tmr_done    (tmr_done),
    .tmr_start   (tmr_start),
    .bus_pwr_req (bus_pwr_req),
    .sub_pwr_req (sub_pwr_req),
    .seq         (seq),
    .live        (live)
  );

  pis_settle_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .done  (tmr_done)
  );

  pis_regfile #(.DW(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live),
    .sw_wr    (reg_wr_en),
    .sw_addr  (reg_addr),
    .sw_wdata (reg_wdata),
    .seq      (seq),
    .rdata    (reg_rdata),
    .rst_bits (rst_bits),
    .clk_bits (clk_bits)
  );

  assign sub_rst_n  = rst_bits;
  assign sub_clk_en = clk_bits;

  logic sw_touch;
  assign sw_touch = reg_wr_en && (reg_addr == '0);

  p_bridge_at_bus_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_pwr_req) |-> (sub_rst_n == '0 && sub_clk_en == '1));

  p_dead_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_pwr_req && bus_pwr_ack) |-> (reg_rdata == '0));

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    logic [HC_W-1:0] hi_cnt_q, hi_cnt_d;

    always_comb begin
      hi_cnt_d = '0;
      if (sub_pwr_req[g] && sub_pwr_ack[g])
        hi_cnt_d = (hi_cnt_q == HC_W'(WAIT_CYC)) ? hi_cnt_q : hi_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_cnt_q <= '0;
      else        hi_cnt_q <= hi_cnt_d;
    end

    p_rst_before_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sub_pwr_req[g]) |-> (!sub_rst_n[g] && sub_clk_en[g]));

    p_safe_before_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sub_pwr_req[g]) |-> (!sub_rst_n[g] && !sub_clk_en[g]));

    p_settle_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sub_rst_n[g]) && !$past(sw_touch)) |-> (hi_cnt_q >= HC_W'(WAIT_CYC)));
  end
endmodule

// File: tb/pwr_island_seq_tb_top.sv
module pwr_island_seq_tb_top;
  localparam int WAIT_CYC = 250;
  localparam int WD_LIMIT = 150_000;

  logic        clk, rst_n;
  logic [2:0]  pon_req, poff_req;
  logic        bus_pwr_req, bus_pwr_ack;
  logic [2:0]  sub_pwr_req, sub_pwr_ack;
  logic [2:0]  sub_rst_n, sub_clk_en;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0;
  int fails  = 0;

  pwr_island_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pon_req(pon_req), .poff_req(poff_req),
    .bus_pwr_req(bus_pwr_req), .bus_pwr_ack(bus_pwr_ack),
    .sub_pwr_req(sub_pwr_req), .sub_pwr_ack(sub_pwr_ack),
    .sub_rst_n(sub_rst_n), .sub_clk_en(sub_clk_en),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // power controller stub: acknowledge follows request after three cycles
  logic [2:0] bus_sh;
  logic [2:0] sub_d1, sub_d2, sub_d3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_sh <= '0; sub_d1 <= '0; sub_d2 <= '0; sub_d3 <= '0;
    end else begin
      bus_sh <= {bus_sh[1:0], bus_pwr_req};
      sub_d1 <= sub_pwr_req; sub_d2 <= sub_d1; sub_d3 <= sub_d2;
    end
  end
  assign bus_pwr_ack = bus_sh[2];
  assign sub_pwr_ack = sub_d3;

  // {address, expected read} after G1 alone is up
  localparam logic [39:0] RD_TAB [0:7] = '{
    {8'h00, 32'h0000_0002},
    {8'h04, 32'h0000_0002},
    {8'h08, 32'hFFFF_FFFF},
    {8'h0C, 32'hFFFF_FFFF},
    {8'h10, 32'hFFFF_FFFF},
    {8'h14, 32'hFFFF_FFFF},
    {8'h18, 32'h0000_0000},
    {8'h06, 32'h0000_0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] on_m, input logic [2:0] off_m);
    @(negedge clk);
    pon_req = on_m; poff_req = off_m;
    @(negedge clk);
    pon_req = '0; poff_req = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    bit ok;
    rst_n = 1'b0; pon_req = '0; poff_req = '0;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: reset state
    chk(sub_rst_n == 0 && sub_clk_en == 0 && !bus_pwr_req && sub_pwr_req == 0,
        "R5 reset outputs", {23'd0, bus_pwr_req, sub_pwr_req, sub_rst_n, sub_clk_en}, 32'd0);

    // R9: writes and reads while the island is off
    wr(8'h04, 32'h7);
    rd(8'h04, v);
    chk(v == 0 && sub_clk_en == 0, "R9 dead write/read", v, 32'd0);

    // bring up G1
    pulse(3'b010, 3'b000);
    while (!bus_pwr_req) @(negedge clk);
    chk(sub_pwr_req == 0, "R1 bus requested first", {29'd0, sub_pwr_req}, 32'd0);
    while (!(bus_pwr_ack && sub_clk_en == 3'b111)) @(negedge clk);
    chk(sub_rst_n == 0, "R2 bridge resets low", {29'd0, sub_rst_n}, 32'd0);
    rd(8'h08, v);
    chk(v == 0, "R13 straps cleared before restore", v, 32'd0);
    while (!sub_pwr_req[1]) @(negedge clk);
    chk(!sub_rst_n[1] && sub_clk_en == 3'b010, "R3 reset low clock on at request (R2 clocks back)",
        {26'd0, sub_rst_n, sub_clk_en}, {26'd0, 3'b000, 3'b010});
    while (!sub_pwr_ack[1]) @(negedge clk);
    n = 0;
    while (!sub_rst_n[1]) begin @(negedge clk); n++; end
    chk(n >= WAIT_CYC && n <= WAIT_CYC + 6, "R4 settle window", n, WAIT_CYC);
    repeat (3) @(negedge clk);

    // R5/R10: register table walk
    for (int i = 0; i < 8; i++) begin
      rd(RD_TAB[i][39:32], v);
      chk(v == RD_TAB[i][31:0], $sformatf("R5 R10 read at %h", RD_TAB[i][39:32]), v, RD_TAB[i][31:0]);
    end

    // R10: software clock gating and strap write while up
    wr(8'h04, 32'h0);
    chk(sub_clk_en == 0 && sub_rst_n == 3'b010, "R10 sw clock gate",
        {26'd0, sub_rst_n, sub_clk_en}, {26'd0, 3'b010, 3'b000});
    wr(8'h04, 32'h2);
    wr(8'h08, 32'h0000_00A5);
    rd(8'h08, v);
    chk(v == 32'hA5, "R10 strap write", v, 32'hA5);

    // R11: G2 and H1 together, G2 first
    pulse(3'b101, 3'b000);
    while (sub_pwr_req == 3'b010) @(negedge clk);
    chk(sub_pwr_req == 3'b011, "R11 G2 before H1", {29'd0, sub_pwr_req}, 32'h3);
    while (sub_rst_n != 3'b111) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(sub_clk_en == 3'b111 && sub_pwr_req == 3'b111, "R11 all three on",
        {26'd0, sub_pwr_req, sub_clk_en}, {26'd0, 3'b111, 3'b111});

    // R12: on requests for domains already on
    pulse(3'b111, 3'b000);
    ok = 1'b1;
    repeat (600) begin
      @(negedge clk);
      if (sub_pwr_req != 3'b111 || sub_rst_n != 3'b111 || sub_clk_en != 3'b111) ok = 1'b0;
    end
    chk(ok, "R12 redundant power-on ignored", {31'd0, ok}, 32'd1);

    // R6/R7: G1 off
    pulse(3'b000, 3'b010);
    while (sub_pwr_req[1]) @(negedge clk);
    chk(!sub_rst_n[1] && !sub_clk_en[1], "R6 safe before drop",
        {26'd0, sub_rst_n, sub_clk_en}, {26'd0, 3'b101, 3'b101});
    repeat (20) @(negedge clk);
    chk(bus_pwr_req && bus_pwr_ack && sub_rst_n == 3'b101, "R7 bus stays up",
        {27'd0, bus_pwr_req, bus_pwr_ack, sub_rst_n}, {27'd0, 2'b11, 3'b101});

    // R8: last domains off, bus goes down
    pulse(3'b000, 3'b101);
    while (bus_pwr_req) @(negedge clk);
    chk(sub_rst_n == 0 && sub_clk_en == 3'b111, "R8 bridge pattern at bus drop",
        {26'd0, sub_rst_n, sub_clk_en}, {26'd0, 3'b000, 3'b111});
    while (bus_pwr_ack) @(negedge clk);
    repeat (3) @(negedge clk);
    rd(8'h0C, v);
    chk(v == 0 && sub_rst_n == 0 && sub_clk_en == 0, "R8 R9 island lost",
        {v[25:0], sub_rst_n, sub_clk_en}, 32'd0);

    // R12: off request for a domain already off
    pulse(3'b000, 3'b010);
    ok = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (bus_pwr_req || sub_pwr_req != 0) ok = 1'b0;
    end
    chk(ok, "R12 redundant power-off ignored", {31'd0, ok}, 32'd1);

    // R11/R13: G1 and G2 together after collapse
    pulse(3'b011, 3'b000);
    while (sub_pwr_req == 0) @(negedge clk);
    chk(sub_pwr_req == 3'b010, "R11 G1 served first", {29'd0, sub_pwr_req}, 32'h2);
    while (sub_rst_n != 3'b011) @(negedge clk);
    repeat (3) @(negedge clk);
    rd(8'h08, v);
    chk(v == 32'hFFFF_FFFF, "R13 strap restored after collapse", v, 32'hFFFF_FFFF);
    rd(8'h14, v);
    chk(v == 32'hFFFF_FFFF, "R13 last strap restored", v, 32'hFFFF_FFFF);

    finish_run();
  end
endmodule